// File: doc/BRIEF.md
# Scan Shift-Capture Sequencer

This block runs one scan test pattern at a time. A start request latches the pattern settings (shift length, settle count and capture mode), then the block raises scan-enable, issues the programmed number of shift clock enables, drops scan-enable and waits out a settle window. It then issues the capture clock enable, either a single pulse or a launch-and-capture pair for at-speed testing. It keeps scan-enable low through a short post-capture cycle, pulses a done flag and returns to idle, ready for the next pattern, whose shift phase unloads the captured response.

Scan-enable reaches the scan flops through a chain of register stages that stands for a balanced distribution tree (depth `SE_STAGES`). A second, shorter copy (depth `FAST_STAGES`) serves the at-speed capture flops. Because the distributed copy lags the sequencer's internal state, shift pulses begin only once scan-enable has arrived at the end of the chain. Capture waits at least as many cycles as the chain is deep, so every copy is back at zero before the capture pulse.

The pipeline depths are elaboration-time parameters. A settle count below the distribution depth is raised to that depth, and a sticky flag records the misprogramming.

Top module: `scanseq_top`

## Requirements
- R1: After reset every output is 0, the block is idle and the error flag is clear.
- R2: For shift length L, `shift_ce` is high on exactly L consecutive cycles, the first one `SE_STAGES` cycles after the cycle in which start is accepted, and `se_dist` is 1 on every one of those cycles.
- R3: The internal scan-enable falls only in the cycle after the last shift pulse, so `se_dist` stays 1 through the final shift pulse and falls `SE_STAGES` cycles after the shift phase ends.
- R4: The first capture pulse comes E cycles after the last shift cycle, where E is the effective settle count, and `se_dist` and `se_fast` are both 0 on every capture pulse and on the cycle that follows it.
- R5: E equals the programmed settle count when that count is at least `SE_STAGES`, and equals `SE_STAGES` otherwise. Accepting a start with a settle count below `SE_STAGES` sets `settle_err`, which stays set until reset.
- R6: With `at_speed`=1, `capture_ce` is high on two consecutive cycles (launch, then capture). With `at_speed`=0 it is high on one cycle.
- R7: `se_fast` is the internal scan-enable delayed by `FAST_STAGES` cycles. It is high from cycle `FAST_STAGES` up to cycle L+`SE_STAGES`+`FAST_STAGES`−1 after acceptance.
- R8: `done` is high for exactly one cycle, the cycle after the last capture pulse, after which the block is idle and accepts a new start.
- R9: A start while the block is busy is ignored, and the settings latched at acceptance stay in force for the whole pattern.
- R10: A shift length of 0 produces no shift pulses, but the settle and capture phases still run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pattern when the block is idle |
| at_speed | input | 1 | 1 = launch and capture pulse pair, 0 = single capture pulse |
| shift_len | input | 16 | Number of shift pulses |
| settle_cnt | input | 8 | Requested cycles from the last shift cycle to the first capture |
| se_dist | output | 1 | Scan-enable at the end of the balanced distribution chain |
| se_fast | output | 1 | Low-latency scan-enable copy for at-speed capture flops |
| shift_ce | output | 1 | Shift clock enable |
| capture_ce | output | 1 | Capture clock enable |
| done | output | 1 | One-cycle pulse at the end of a pattern |
| settle_err | output | 1 | Sticky flag: a settle count shorter than the distribution depth was requested |

## Verification
The bench aims at the boundaries where scan-enable and the clock enables must not overlap wrongly. It covers zero shift length, settle counts below, at and above the chain depth, and back-to-back patterns in both capture modes. A sequencer that dropped scan-enable one cycle early would show `se_dist` low on the last shift pulse. One that did not clamp the settle count would pulse capture while the distributed copy was still high. Miscounting the at-speed pair would show as one or three capture pulses. A second start issued mid-shift with different settings checks that a busy sequencer does not restart or pick up new values.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SETTLE,
        ST_CAPTURE,
        ST_POST
    } seq_state_t;

    // Pattern settings held for the life of one pattern
    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  settle;
        logic        fast_mode;
    } pat_cfg_t;

    // Settle length actually used: never shorter than the distribution depth
    function automatic logic [7:0] clamp_settle(input logic [7:0] req, input int unsigned depth);
        if (int'(req) < int'(depth)) return 8'(depth);
        return req;
    endfunction

endpackage

// File: rtl/scanseq_pipe.sv
module scanseq_pipe #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= (chain << 1) | STAGES'(d);
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scanseq_fsm.sv
module scanseq_fsm
    import scanseq_pkg::*;
#(
    parameter int SE_STAGES = 4,
    parameter int LEN_W     = 16,
    parameter int SETTLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                at_speed,
    input  logic [LEN_W-1:0]    shift_len,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                se_raw,
    output logic                shift_ce,
    output logic                capture_ce,
    output logic                done,
    output logic                settle_err
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(SE_STAGES);

    seq_state_t       state;
    pat_cfg_t         cfg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shift_last;
    logic [CNT_W-1:0] settle_last;

    assign shift_last  = DEPTH + CNT_W'(cfg.len) - CNT_W'(1);
    assign settle_last = CNT_W'(cfg.settle) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg        <= '0;
            cnt        <= '0;
            settle_err <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg.len       <= shift_len;
                        cfg.settle    <= clamp_settle(settle_cnt, SE_STAGES);
                        cfg.fast_mode <= at_speed;
                        cnt           <= '0;
                        state         <= ST_SHIFT;
                        if (int'(settle_cnt) < SE_STAGES) settle_err <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt == shift_last) begin
                        cnt   <= '0;
                        state <= ST_SETTLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (cnt == settle_last) begin
                        cnt   <= '0;
                        state <= ST_CAPTURE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_CAPTURE: begin
                    if (cfg.fast_mode && cnt == '0) begin
                        cnt <= CNT_W'(1);
                    end else begin
                        cnt   <= '0;
                        state <= ST_POST;
                    end
                end
                ST_POST: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        se_raw     = (state == ST_SHIFT);
        shift_ce   = (state == ST_SHIFT) && (cnt >= DEPTH);
        capture_ce = (state == ST_CAPTURE);
        done       = (state == ST_POST);
    end
endmodule

// File: rtl/scanseq_top.sv
module scanseq_top #(
    parameter int SE_STAGES   = 4,
    parameter int FAST_STAGES = 1,
    parameter int LEN_W       = 16,
    parameter int SETTLE_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                at_speed,
    input  logic [LEN_W-1:0]    shift_len,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                se_dist,
    output logic                se_fast,
    output logic                shift_ce,
    output logic                capture_ce,
    output logic                done,
    output logic                settle_err
);
    logic se_raw;

    scanseq_fsm #(
        .SE_STAGES (SE_STAGES),
        .LEN_W     (LEN_W),
        .SETTLE_W  (SETTLE_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .at_speed   (at_speed),
        .shift_len  (shift_len),
        .settle_cnt (settle_cnt),
        .se_raw     (se_raw),
        .shift_ce   (shift_ce),
        .capture_ce (capture_ce),
        .done       (done),
        .settle_err (settle_err)
    );

    // Balanced distribution chain to the scan flops
    scanseq_pipe #(.STAGES(SE_STAGES)) u_tree (
        .clk (clk),
        .rst (rst),
        .d   (se_raw),
        .q   (se_dist)
    );

    // Short, lightly loaded copy for at-speed capture flops
    scanseq_pipe #(.STAGES(FAST_STAGES)) u_fast (
        .clk (clk),
        .rst (rst),
        .d   (se_raw),
        .q   (se_fast)
    );
endmodule

// File: rtl/scanseq_chk.sv
module scanseq_chk (
    input logic clk,
    input logic rst,
    input logic se_dist,
    input logic se_fast,
    input logic shift_ce,
    input logic capture_ce,
    input logic done,
    input logic settle_err
);
    a_r2_shift_sees_se: assert property (@(posedge clk) disable iff (rst)
        shift_ce |-> se_dist);

    a_r4_capture_se_low: assert property (@(posedge clk) disable iff (rst)
        capture_ce |-> (!se_dist && !se_fast));

    a_r4_se_held_after_capture: assert property (@(posedge clk) disable iff (rst)
        capture_ce |=> !se_dist);

    a_r3_no_shift_with_capture: assert property (@(posedge clk) disable iff (rst)
        !(shift_ce && capture_ce));

    a_r6_capture_at_most_two: assert property (@(posedge clk) disable iff (rst)
        (capture_ce && $past(capture_ce)) |=> !capture_ce);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_capture: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(capture_ce));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        settle_err |=> settle_err);
endmodule

bind scanseq_top scanseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .se_dist    (se_dist),
    .se_fast    (se_fast),
    .shift_ce   (shift_ce),
    .capture_ce (capture_ce),
    .done       (done),
    .settle_err (settle_err)
);

// File: tb/tb_scanseq_top.sv
`timescale 1ns/1ps
module tb_scanseq_top;
    localparam int D = 4;
    localparam int F = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        at_speed = 1'b0;
    logic [15:0] shift_len = '0;
    logic [7:0]  settle_cnt = '0;
    logic se_dist, se_fast, shift_ce, capture_ce, done, settle_err;

    int checks = 0;
    int errors = 0;
    bit exp_err = 1'b0;
    int wd = 0;

    always #2.5 clk = ~clk;

    scanseq_top #(.SE_STAGES(D), .FAST_STAGES(F)) dut (
        .clk(clk), .rst(rst), .start(start), .at_speed(at_speed),
        .shift_len(shift_len), .settle_cnt(settle_cnt),
        .se_dist(se_dist), .se_fast(se_fast), .shift_ce(shift_ce),
        .capture_ce(capture_ce), .done(done), .settle_err(settle_err)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int eff_of(input int s);
        return (s < D) ? D : s;
    endfunction
    function automatic bit e_shift(input int c, input int l);
        return c >= D && c < D + l;
    endfunction
    function automatic bit e_cap(input int c, input int l, input int e, input bit a);
        return c >= D + l + e && c < D + l + e + (a ? 2 : 1);
    endfunction
    function automatic bit e_done(input int c, input int l, input int e, input bit a);
        return c == D + l + e + (a ? 2 : 1);
    endfunction
    function automatic bit e_tree(input int c, input int l);
        return c >= D && c < 2 * D + l;
    endfunction
    function automatic bit e_fast(input int c, input int l);
        return c >= F && c < D + l + F;
    endfunction

    // One pattern; ign = issue a second start with other settings mid-shift (R9)
    task automatic run(input int l, input int s, input bit a, input bit ign);
        int e = eff_of(s);
        int last = D + l + e + (a ? 2 : 1) + 3;
        int m_sh = 0, m_cap = 0, m_dn = 0, m_tr = 0, m_fs = 0, n_sh = 0, n_cap = 0;
        shift_len = 16'(l); settle_cnt = 8'(s); at_speed = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_err = exp_err | (s < D);
        for (int c = 0; c <= last; c++) begin
            if (c > 0) @(negedge clk);
            if (shift_ce   !== e_shift(c, l))       m_sh++;
            if (capture_ce !== e_cap(c, l, e, a))   m_cap++;
            if (done       !== e_done(c, l, e, a))  m_dn++;
            if (se_dist    !== e_tree(c, l))        m_tr++;
            if (se_fast    !== e_fast(c, l))        m_fs++;
            if (shift_ce === 1'b1)   n_sh++;
            if (capture_ce === 1'b1) n_cap++;
            if (ign && c == 2) begin
                start = 1'b1; shift_len = 16'(l + 7); settle_cnt = 8'(s + 9); at_speed = ~a;
            end
            if (ign && c == 3) start = 1'b0;
        end
        chk(m_sh == 0,  $sformatf("R2 R10 shift_ce timing L=%0d (mismatch cycles)", l), m_sh, 0);
        chk(n_sh == l,  "R2 shift pulse count", n_sh, l);
        chk(m_tr == 0,  $sformatf("R3 se_dist window L=%0d (mismatch cycles)", l), m_tr, 0);
        chk(m_cap == 0, $sformatf("R4 R5 capture timing S=%0d (mismatch cycles)", s), m_cap, 0);
        chk(n_cap == (a ? 2 : 1), "R6 capture pulse count", n_cap, a ? 2 : 1);
        chk(m_fs == 0,  "R7 se_fast window (mismatch cycles)", m_fs, 0);
        chk(m_dn == 0,  "R8 done pulse (mismatch cycles)", m_dn, 0);
        chk(settle_err === exp_err, "R5 settle_err", int'(settle_err), int'(exp_err));
        if (ign) chk(m_sh + m_cap + m_dn == 0, "R9 busy start ignored (mismatch cycles)", m_sh + m_cap + m_dn, 0);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({se_dist, se_fast, shift_ce, capture_ce, done, settle_err} == 6'b0,
            "R1 outputs after reset", int'({se_dist, se_fast, shift_ce, capture_ce, done, settle_err}), 0);
        run(5, 6, 1'b0, 1'b0);
        run(0, 4, 1'b1, 1'b0);   // R10 zero length, settle equal to depth
        run(1, 7, 1'b1, 1'b0);
        run(8, 5, 1'b1, 1'b1);   // R9 busy start
        run(3, 0, 1'b0, 1'b0);   // R5 clamp, error set
        run(2, 9, 1'b0, 1'b0);   // R5 error stays set
        for (int i = 0; i < 16; i++) begin
            int l = int'($urandom_range(0, 40));
            int s = int'($urandom_range(0, 10));
            bit a = 1'($urandom_range(0, 1));
            run(l, s, a, 1'($urandom_range(0, 1)));
        end
        // R5 reset clears sticky flag, R1 idle again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
        @(negedge clk);
        chk(settle_err === 1'b0, "R5 settle_err cleared by reset", int'(settle_err), 0);
        chk(se_dist === 1'b0 && done === 1'b0, "R1 idle after reset", int'({se_dist, done}), 0);
        run(2, 3, 1'b1, 1'b0);
        finish_up();
    end
endmodule